// File: doc/BRIEF.md
# I2C Slave Byte-Memory Controller

This block is a standard-mode I2C slave in front of a 256-byte memory held in registers. It watches the bus lines through a synchroniser clocked by a fast system clock. It recognises START, repeated START and STOP, and answers one 7-bit device address. That address joins four fixed upper bits to three strap inputs, so up to eight copies can share one bus. The block drives SDA only as an open-drain pull-down enable.

A write first sets an internal byte pointer, then places up to eight bytes into a page latch. The latch is copied into the array only after STOP, at the end of a programming interval whose length is a parameter. During that interval the block ignores its own address. Three kinds of read share the same pointer: a read from the current pointer, a random read (pointer set by a write and then a repeated START), and a sequential read. During a sequential read the pointer moves freely through the whole array.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The device address byte is acknowledged only when its upper seven bits equal {DEV_HI, strap}, where bit 0 is the read flag (1 = read). Any other address leaves SDA released during the acknowledge slot, and the rest of the transfer is ignored until the next START.
- R2: Every byte travels most significant bit first. The receiver of each byte answers in a ninth clock (low = acknowledge). The slave changes SDA only after a falling SCL edge, or when it detects START or STOP.
- R3: A write-mode address followed by a word address and one data byte stores that byte at the word address once the programming interval ends.
- R4: During a write, the pointer's low three bits advance after each data byte and wrap within the 8-byte page, while bits 7:3 stay fixed. A ninth or later byte therefore overwrites an earlier slot of the same page.
- R5: Only the page slots that received data in the current write are changed in the array. The other bytes of that page keep their old values.
- R6: After a STOP that ends a write carrying data, the block counts PROG_CYCLES clocks. While the count runs it does not acknowledge its address. After the count ends it acknowledges again.
- R7: A read-mode address without a preceding word address returns the byte at the current pointer. The pointer advances by one after every byte sent, including the last byte of a read.
- R8: A random read (write-mode address, word address, repeated START, read-mode address) returns the byte stored at that word address.
- R9: A sequential read continues while the master acknowledges. The pointer crosses page boundaries and wraps from 0xFF to 0x00.
- R10: When the master does not acknowledge a read byte, the slave releases SDA and keeps it released until the next START.
- R11: Synchronous reset clears the pointer to 0x00, empties the page latch, returns the protocol to idle with SDA released, and leaves the array contents unchanged.
- R12: A write that carries only a word address and then STOP starts no programming interval. The address is acknowledged straight away, and the pointer holds the written word address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired value) |
| strap | input | 3 | Low three bits of the device address |
| sda_oe | output | 1 | Pull SDA low when 1, release when 0 |

## Verification
The bench builds the block with PROG_CYCLES = 1000. This makes the busy window longer than one address byte, so an address sent right after a write's STOP falls inside the window and must be refused. A short wait afterwards then shows the address acknowledged again. DEV_HI keeps its default of 4'b1010. The bench changes strap during the run, so a single build covers both a matching and a non-matching address. Each bus quarter-bit lasts 8 system clocks, which keeps every transfer short while leaving room for the synchroniser delay.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter logic [3:0] DEV_HI = 4'b1010,
  parameter int PROG_CYCLES = 20000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap,
  output logic       sda_oe
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {IDLE = 3'd0, DEV = 3'd1, WORD = 3'd2, DATA = 3'd3, READ = 3'd4} st_t;

  logic [2:0] scl_s, sda_s;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh, tx, ptr;
  logic [7:0] page [8];
  logic [7:0] vld;
  logic       pend;
  logic [CW-1:0] busy_cnt;
  logic [7:0] mem [256];

  wire sda_v     = sda_s[1];
  wire scl_rise  = scl_s[1] & ~scl_s[2];
  wire scl_fall  = ~scl_s[1] & scl_s[2];
  wire start_det = scl_s[1] & scl_s[2] & ~sda_s[1] & sda_s[2];
  wire stop_det  = scl_s[1] & scl_s[2] & sda_s[1] & ~sda_s[2];
  wire match     = (sh[7:1] == {DEV_HI, strap}) && (busy_cnt == '0);
  wire [7:0] ptr_nx = ptr + 8'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_s <= 3'b111;
      sda_s <= 3'b111;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= IDLE;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      ptr      <= '0;
      vld      <= '0;
      pend     <= 1'b0;
      busy_cnt <= '0;
      sda_oe   <= 1'b0;
      for (int i = 0; i < 8; i++) page[i] <= '0;
    end else begin
      if (busy_cnt != '0) busy_cnt <= busy_cnt - CW'(1);
      if (start_det) begin
        st     <= DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= IDLE;
        sda_oe <= 1'b0;
        if (pend) begin
          busy_cnt <= CW'(PROG_CYCLES);
          pend     <= 1'b0;
        end
      end else if (st != IDLE) begin
        if (scl_rise) begin
          if (st == READ) begin
            if (cnt < 4'd8) begin
              cnt <= cnt + 4'd1;
              tx  <= {tx[6:0], 1'b0};
            end else if (cnt == 4'd8) begin
              ptr <= ptr_nx;
              if (sda_v) st <= IDLE;
              else begin
                tx  <= mem[ptr_nx];
                cnt <= '0;
              end
            end
          end else if (cnt < 4'd8) begin
            sh  <= {sh[6:0], sda_v};
            cnt <= cnt + 4'd1;
          end
        end
        if (scl_fall) begin
          if (cnt == 4'd9) begin
            cnt    <= '0;
            sda_oe <= (st == READ) ? ~tx[7] : 1'b0;
          end else if (st == READ) begin
            sda_oe <= (cnt < 4'd8) ? ~tx[7] : 1'b0;
          end else if (cnt == 4'd8) begin
            case (st)
              DEV: begin
                if (match) begin
                  sda_oe <= 1'b1;
                  cnt    <= 4'd9;
                  if (sh[0]) begin
                    st <= READ;
                    tx <= mem[ptr];
                  end else st <= WORD;
                end else st <= IDLE;
              end
              WORD: begin
                ptr    <= sh;
                vld    <= '0;
                sda_oe <= 1'b1;
                cnt    <= 4'd9;
                st     <= DATA;
              end
              DATA: begin
                page[ptr[2:0]] <= sh;
                vld[ptr[2:0]]  <= 1'b1;
                pend           <= 1'b1;
                ptr[2:0]       <= ptr[2:0] + 3'd1;
                sda_oe         <= 1'b1;
                cnt            <= 4'd9;
              end
              default: st <= IDLE;
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy_cnt == CW'(1))
      for (int i = 0; i < 8; i++)
        if (vld[i]) mem[{ptr[7:3], 3'(i)}] <= page[i];
  end
endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
module i2c_eeprom_slave_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          sda_oe,
  input logic [2:0]    st,
  input logic [3:0]    cnt,
  input logic [7:0]    ptr,
  input logic [CW-1:0] busy_cnt,
  input logic          scl_fall,
  input logic          start_det,
  input logic          stop_det
);
  p_stop_release_r10: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  p_oe_after_fall_r2: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

  p_busy_nack_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_cnt != '0 && st == 3'd1 && cnt == 4'd8 && scl_fall && !start_det && !stop_det) |=> !sda_oe);

  p_busy_countdown_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_cnt != '0) |=> (busy_cnt == $past(busy_cnt) - CW'(1)));

  p_page_upper_fixed_r4: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd3 && $past(st) == 3'd3) |-> (ptr[7:3] == $past(ptr[7:3])));

  p_idle_released_r1: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd0 && $past(st) == 3'd0) |-> !sda_oe);
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .st(st), .cnt(cnt), .ptr(ptr),
  .busy_cnt(busy_cnt), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
);

// File: tb/tb_i2c_eeprom_slave.sv
`timescale 1ns/1ps
module tb_i2c_eeprom_slave;
  localparam int Q = 8;
  localparam int PROG = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] rd_val;
  event       rd_ev;
  logic [7:0] dbuf [16];

  always #2 clk = ~clk;

  i2c_eeprom_slave #(.DEV_HI(4'b1010), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .strap(strap), .sda_oe(sda_oe)
  );

  function automatic logic [7:0] dev(input logic [2:0] s, input logic rd);
    return {4'b1010, s, rd};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic q(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; q(); m_scl = 1'b1; q(2); m_scl = 1'b0;
    end
    m_sda = 1'b1; q(); m_scl = 1'b1; q();
    ack = ~sda_line;
    q(); m_scl = 1'b0; q();
  endtask

  task automatic recv_byte(input logic nack);
    logic [7:0] v;
    v = '0;
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      q(); m_scl = 1'b1; q(); v = {v[6:0], sda_line}; q(); m_scl = 1'b0;
    end
    q(); m_sda = nack; q(); m_scl = 1'b1; q(2); m_scl = 1'b0; q(); m_sda = 1'b1;
    rd_val = v;
    -> rd_ev;
  endtask

  task automatic expect_rd(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic send_chk(input logic [7:0] b, input logic exp_ack, input string tag);
    logic a;
    send_byte(b, a);
    chk(a == exp_ack, tag, int'(a), int'(exp_ack));
  endtask

  task automatic write_seq(input logic [7:0] wa, input int n, input string tag);
    i2c_start();
    send_chk(dev(3'b101, 1'b0), 1'b1, tag);
    send_chk(wa, 1'b1, tag);
    for (int i = 0; i < n; i++) send_chk(dbuf[i], 1'b1, tag);
    i2c_stop();
  endtask

  task automatic read_bytes(input int n, input bit extra_clk);
    for (int i = 0; i < n; i++) recv_byte(i == n - 1);
    if (extra_clk) begin
      q(); m_scl = 1'b1; q();
      chk(sda_line == 1'b1, "R10", int'(sda_line), 1);
      q(); m_scl = 1'b0; q();
    end
    i2c_stop();
  endtask

  task automatic rand_read(input logic [7:0] wa, input int n, input string tag);
    i2c_start();
    send_chk(dev(3'b101, 1'b0), 1'b1, tag);
    send_chk(wa, 1'b1, tag);
    i2c_start();
    send_chk(dev(3'b101, 1'b1), 1'b1, tag);
    read_bytes(n, 1'b0);
  endtask

  initial begin : monitor
    forever begin
      @(rd_ev);
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected read", int'(rd_val), 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rd_val == e, t, int'(rd_val), int'(e));
      end
    end
  end

  initial begin : watchdog
    int n;
    n = 0;
    while (!done && n < 150000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", n, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (5) @(negedge clk);
    rst = 1'b0;
    q();
    chk(sda_oe == 1'b0, "R11 reset releases SDA", int'(sda_oe), 0);

    // R1: strap mismatch is refused
    i2c_start();
    send_chk(dev(3'b011, 1'b0), 1'b0, "R1 wrong address");
    i2c_stop();

    // R3 byte write; R6 refused during programming
    dbuf[0] = 8'h01;
    write_seq(8'h10, 1, "R3");
    i2c_start();
    send_chk(dev(3'b101, 1'b0), 1'b0, "R6 busy nack");
    i2c_stop();
    repeat (PROG + 100) @(negedge clk);
    expect_rd(8'h01, "R8 R2 R3 random read");
    rand_read(8'h10, 1, "R6 ack after busy");

    // R5 partial page update
    for (int i = 0; i < 8; i++) dbuf[i] = 8'h40 + 8'(i);
    write_seq(8'h30, 8, "R4");
    repeat (PROG + 100) @(negedge clk);
    dbuf[0] = 8'h5A; dbuf[1] = 8'h5B;
    write_seq(8'h33, 2, "R5");
    repeat (PROG + 100) @(negedge clk);
    expect_rd(8'h40, "R5"); expect_rd(8'h41, "R5"); expect_rd(8'h42, "R5");
    expect_rd(8'h5A, "R5"); expect_rd(8'h5B, "R5"); expect_rd(8'h45, "R5");
    expect_rd(8'h46, "R5"); expect_rd(8'h47, "R5");
    rand_read(8'h30, 8, "R5");

    // R4 ten bytes wrap within page 0x18
    for (int i = 0; i < 10; i++) dbuf[i] = 8'h80 + 8'(i);
    write_seq(8'h1B, 10, "R4");
    repeat (PROG + 100) @(negedge clk);
    expect_rd(8'h85, "R4"); expect_rd(8'h86, "R4"); expect_rd(8'h87, "R4");
    expect_rd(8'h88, "R4"); expect_rd(8'h89, "R4"); expect_rd(8'h82, "R4");
    expect_rd(8'h83, "R4"); expect_rd(8'h84, "R4");
    rand_read(8'h18, 8, "R4");

    // R9 wrap from 0xFF to 0x00
    dbuf[0] = 8'hC1; dbuf[1] = 8'hC2;
    write_seq(8'hFE, 2, "R9");
    repeat (PROG + 100) @(negedge clk);
    dbuf[0] = 8'hC3;
    write_seq(8'h00, 1, "R9");
    repeat (PROG + 100) @(negedge clk);
    expect_rd(8'hC1, "R9"); expect_rd(8'hC2, "R9");
    i2c_start();
    send_chk(dev(3'b101, 1'b0), 1'b1, "R9");
    send_chk(8'hFE, 1'b1, "R9");
    i2c_start();
    send_chk(dev(3'b101, 1'b1), 1'b1, "R9");
    read_bytes(2, 1'b1);
    expect_rd(8'hC3, "R9 R7 current read after wrap");
    i2c_start();
    send_chk(dev(3'b101, 1'b1), 1'b1, "R7");
    read_bytes(1, 1'b0);

    // R7 pointer advances after last byte
    expect_rd(8'h40, "R8");
    rand_read(8'h30, 1, "R8");
    expect_rd(8'h41, "R7 pointer advanced");
    i2c_start();
    send_chk(dev(3'b101, 1'b1), 1'b1, "R7");
    read_bytes(1, 1'b1);

    // R12 word-address-only write
    i2c_start();
    send_chk(dev(3'b101, 1'b0), 1'b1, "R12");
    send_chk(8'h31, 1'b1, "R12");
    i2c_stop();
    i2c_start();
    send_chk(dev(3'b101, 1'b1), 1'b1, "R12 no busy");
    expect_rd(8'h41, "R12 pointer loaded");
    read_bytes(1, 1'b0);

    // R1 strap change
    strap = 3'b011;
    i2c_start();
    send_chk(dev(3'b101, 1'b0), 1'b0, "R1 old strap refused");
    i2c_stop();
    i2c_start();
    send_chk(dev(3'b011, 1'b1), 1'b1, "R1 new strap");
    expect_rd(8'h42, "R1 R7");
    read_bytes(1, 1'b0);
    strap = 3'b101;

    // R11 reset keeps array, clears pointer
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R11", int'(sda_oe), 0);
    rst = 1'b0;
    q();
    i2c_start();
    send_chk(dev(3'b101, 1'b1), 1'b1, "R11");
    expect_rd(8'hC3, "R11 pointer cleared");
    read_bytes(1, 1'b0);

    q(4);
    chk(exp_q.size() == 0, "R7 all reads seen", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule